// File: doc/BRIEF.md
# Multi-Channel Receive Read Port

This block is the receive-side read port that a multi-PHY device presents to a link-layer master. Four channel FIFOs, each holding cell or packet words, share one read path. The master drives an active-low read enable and a 5-bit address. The upper three address bits identify the device against a programmable base value, and the lower two bits name one of the four channels. The all-ones address is reserved as a null address and never selects anything.

Two selection schemes are available. In the latched scheme, a cycle with the enable high loads the address into a selection register, and cycles with the enable low read from the channel held there. In the direct scheme, every cycle with the enable low reads the channel addressed in that same cycle. The popped word leaves through a pipeline with a data word, start-of-frame, end-of-frame, error, valid and odd-parity sidebands, one or two cycles after the read. Output drivers are modelled as enable outputs. Independently of any read, the address also polls the addressed channel for available data.

Top module: `rx_read_port`

## Requirements
- R1: The read enable `rd_en_n` is active-low and, with `rd_addr`, is sampled on the rising clock edge. After synchronous reset every output enable, `out_val`, `out_data`, the frame flags and `fifo_pop` are 0, and `out_par` is 1.
- R2: With `cfg_mem_mode` = 0, a cycle with `rd_en_n` = 1 loads the decoded address into the selection register and pops nothing. A cycle with `rd_en_n` = 0 pops the channel held in that register, provided it had selected this device.
- R3: With `cfg_mem_mode` = 1, a cycle with `rd_en_n` = 0 pops the channel named by `rd_addr` in that same cycle, and a cycle with `rd_en_n` = 1 pops nothing.
- R4: The device is selected only when `rd_addr[4:2]` equals `cfg_base`. Channel k (0 to 3) is chosen by `rd_addr[1:0]` = k, and `fifo_pop[k]` is the bit that pops it.
- R5: Address 5'h1F never selects a channel, neither for a read, nor for the latched selection, nor for a poll, even when `cfg_base` is 3'b111.
- R6: With `cfg_lat2` = 0, the word popped in the cycle ending at edge e is presented on the outputs right after edge e. With `cfg_lat2` = 1, it is presented one edge later.
- R7: A presented word carries the FIFO word unchanged in `out_data`, with the first frame byte in bits [DATA_W-1:DATA_W-8], together with that word's start-of-frame and error flags.
- R8: End-of-frame is passed only when `cfg_pkt_mode` = 1. In cell mode (`cfg_pkt_mode` = 0), `out_eof` and `out_eof_oe` stay 0.
- R9: When the device is not selected for a cycle, `out_oe` and `out_eof_oe` for that beat are 0. A read of an empty channel pops nothing and gives `out_val` = 0 with zero data and flags.
- R10: `out_par` is odd parity over `out_data`, so `out_data` and `out_par` together hold an odd number of ones.
- R11: One cycle after any edge, `poll_oe` shows whether that edge's address selected the device, and `poll_avail` shows whether the addressed channel was non-empty, whatever the value of `rd_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_mode | input | 1 | 0: latched selection, 1: per-cycle selection |
| cfg_lat2 | input | 1 | 0: one-cycle output latency, 1: two-cycle |
| cfg_pkt_mode | input | 1 | 1: packet mode (end-of-frame used), 0: cell mode |
| cfg_base | input | 3 | Device base compared with the address upper bits |
| rd_en_n | input | 1 | Active-low read enable |
| rd_addr | input | 5 | Device and channel address |
| fifo_empty | input | 4 | Per-channel FIFO empty flags |
| fifo_data | input | 4*DATA_W | Head words of the channel FIFOs, channel k at slice k |
| fifo_sof | input | 4 | Head start-of-frame flags |
| fifo_eof | input | 4 | Head end-of-frame flags |
| fifo_err | input | 4 | Head error flags |
| fifo_pop | output | 4 | One-hot pop strobe to the channel FIFOs |
| out_data | output | DATA_W | Read data word |
| out_par | output | 1 | Odd parity over out_data |
| out_sof | output | 1 | Start-of-frame |
| out_eof | output | 1 | End-of-frame (packet mode) |
| out_err | output | 1 | Error flag |
| out_val | output | 1 | Word is valid |
| out_oe | output | 1 | Drive enable for data, parity, sof, err, val |
| out_eof_oe | output | 1 | Drive enable for end-of-frame |
| poll_avail | output | 1 | Polled channel has data |
| poll_oe | output | 1 | Drive enable for the poll result |

## Verification
The poll path and the read path both act on the same address edge. The poll must report the channel's state from before the pop that this edge performs. The bench provokes this in direct mode by reading the last word of a channel while addressing it, and in latched mode by polling one channel while the latched selection reads another. A behavioural model with per-channel queues computes the pop, the poll result and the delayed beat for every edge. The outputs are compared every cycle, so a poll taken after the pop, or a read that follows the live address where it should follow the latched one, shows up as a mismatch at once.

// File: rtl/rx_port_pkg.sv
`timescale 1ns/1ps
package rx_port_pkg;

  // sideband of one output beat
  typedef struct packed {
    logic drv;   // data-path drive enable
    logic eoe;   // end-of-frame drive enable
    logic vld;
    logic sof;
    logic eof;
    logic err;
    logic par;
  } side_t;

  function automatic side_t side_idle();
    side_t s;
    s     = '0;
    s.par = 1'b1;  // odd parity of an all-zero word
    return s;
  endfunction

endpackage

// File: rtl/rx_addr_decode.sv
`timescale 1ns/1ps
module rx_addr_decode #(
  parameter int ADDR_W = 5,
  parameter int CH_W   = 2,
  localparam int BASE_W = ADDR_W - CH_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  output logic              hit,
  output logic [CH_W-1:0]   ch
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  always_comb begin
    hit = (addr[ADDR_W-1:CH_W] == base) && (addr != NULL_ADDR);
    ch  = addr[CH_W-1:0];
  end
endmodule

// File: rtl/rx_sel_ctrl.sv
`timescale 1ns/1ps
module rx_sel_ctrl #(
  parameter int CH_W = 2,
  localparam int N_CH = 1 << CH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mem_mode,
  input  logic            en_n,
  input  logic            hit_now,
  input  logic [CH_W-1:0] ch_now,
  input  logic [N_CH-1:0] empty,
  output logic            drive,
  output logic [CH_W-1:0] rd_ch,
  output logic            read_ok,
  output logic [N_CH-1:0] pop
);
  logic            sel_hit_q;
  logic [CH_W-1:0] sel_ch_q;
  logic            rd_req;

  always_comb begin
    if (mem_mode) begin
      drive  = !en_n && hit_now;
      rd_ch  = ch_now;
      rd_req = !en_n && hit_now;
    end else begin
      drive  = sel_hit_q;
      rd_ch  = sel_ch_q;
      rd_req = !en_n && sel_hit_q;
    end
    read_ok = rd_req && !empty[rd_ch];
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_pop
    assign pop[k] = read_ok && (rd_ch == CH_W'(k));
  end

  // selection phase of the latched scheme
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hit_q <= 1'b0;
      sel_ch_q  <= '0;
    end else if (!mem_mode && en_n) begin
      sel_hit_q <= hit_now;
      sel_ch_q  <= ch_now;
    end
  end
endmodule

// File: rtl/rx_out_pipe.sv
`timescale 1ns/1ps
module rx_out_pipe
  import rx_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat2,
  input  logic [DATA_W-1:0] in_data,
  input  side_t             in_side,
  output logic [DATA_W-1:0] out_data,
  output side_t             out_side
);
  localparam int STAGES = 2;

  logic [DATA_W-1:0] d_q [STAGES];
  side_t             s_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        d_q[i] <= '0;
        s_q[i] <= side_idle();
      end else if (i == 0) begin
        d_q[i] <= in_data;
        s_q[i] <= in_side;
      end else begin
        d_q[i] <= d_q[i-1];
        s_q[i] <= s_q[i-1];
      end
    end
  end

  always_comb begin
    out_data = lat2 ? d_q[1] : d_q[0];
    out_side = lat2 ? s_q[1] : s_q[0];
  end
endmodule

// File: rtl/rx_read_port.sv
`timescale 1ns/1ps
module rx_read_port
  import rx_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CH_W   = 2,
  localparam int N_CH   = 1 << CH_W,
  localparam int BASE_W = ADDR_W - CH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_mem_mode,
  input  logic                   cfg_lat2,
  input  logic                   cfg_pkt_mode,
  input  logic [BASE_W-1:0]      cfg_base,
  input  logic                   rd_en_n,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [N_CH-1:0]        fifo_empty,
  input  logic [N_CH*DATA_W-1:0] fifo_data,
  input  logic [N_CH-1:0]        fifo_sof,
  input  logic [N_CH-1:0]        fifo_eof,
  input  logic [N_CH-1:0]        fifo_err,
  output logic [N_CH-1:0]        fifo_pop,
  output logic [DATA_W-1:0]      out_data,
  output logic                   out_par,
  output logic                   out_sof,
  output logic                   out_eof,
  output logic                   out_err,
  output logic                   out_val,
  output logic                   out_oe,
  output logic                   out_eof_oe,
  output logic                   poll_avail,
  output logic                   poll_oe
);
  logic            hit_now;
  logic [CH_W-1:0] ch_now;
  logic            drive;
  logic [CH_W-1:0] rd_ch;
  logic            read_ok;
  logic [DATA_W-1:0] beat_data;
  side_t             beat_side;
  logic [DATA_W-1:0] pipe_data;
  side_t             pipe_side;

  rx_addr_decode #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .addr (rd_addr),
    .base (cfg_base),
    .hit  (hit_now),
    .ch   (ch_now)
  );

  rx_sel_ctrl #(.CH_W(CH_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .mem_mode (cfg_mem_mode),
    .en_n     (rd_en_n),
    .hit_now  (hit_now),
    .ch_now   (ch_now),
    .empty    (fifo_empty),
    .drive    (drive),
    .rd_ch    (rd_ch),
    .read_ok  (read_ok),
    .pop      (fifo_pop)
  );

  // assemble the beat from the popped head word
  always_comb begin
    beat_data     = read_ok ? fifo_data[rd_ch*DATA_W +: DATA_W] : '0;
    beat_side.drv = drive;
    beat_side.eoe = drive && cfg_pkt_mode;
    beat_side.vld = read_ok;
    beat_side.sof = read_ok && fifo_sof[rd_ch];
    beat_side.eof = read_ok && cfg_pkt_mode && fifo_eof[rd_ch];
    beat_side.err = read_ok && fifo_err[rd_ch];
    beat_side.par = ~^beat_data;
  end

  rx_out_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .lat2     (cfg_lat2),
    .in_data  (beat_data),
    .in_side  (beat_side),
    .out_data (pipe_data),
    .out_side (pipe_side)
  );

  always_comb begin
    out_data   = pipe_data;
    out_par    = pipe_side.par;
    out_sof    = pipe_side.sof;
    out_eof    = pipe_side.eof;
    out_err    = pipe_side.err;
    out_val    = pipe_side.vld;
    out_oe     = pipe_side.drv;
    out_eof_oe = pipe_side.eoe;
  end

  // status poll, independent of the read enable
  always_ff @(posedge clk) begin
    if (rst) begin
      poll_oe    <= 1'b0;
      poll_avail <= 1'b0;
    end else begin
      poll_oe    <= hit_now;
      poll_avail <= hit_now && !fifo_empty[ch_now];
    end
  end
endmodule

// File: rtl/rx_read_port_chk.sv
`timescale 1ns/1ps
module rx_read_port_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CH_W   = 2,
  localparam int N_CH   = 1 << CH_W,
  localparam int BASE_W = ADDR_W - CH_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_mem_mode,
  input logic              cfg_lat2,
  input logic              cfg_pkt_mode,
  input logic [BASE_W-1:0] cfg_base,
  input logic              rd_en_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [N_CH-1:0]   fifo_empty,
  input logic [N_CH-1:0]   fifo_pop,
  input logic [DATA_W-1:0] out_data,
  input logic              out_eof,
  input logic              out_val,
  input logic              out_oe,
  input logic              out_eof_oe,
  input logic              poll_avail,
  input logic              poll_oe
);
  p_pop_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_pop));
  p_latch_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mem_mode && rd_en_n) |-> (fifo_pop == '0));
  p_direct_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_mem_mode && rd_en_n) |-> (fifo_pop == '0));
  p_base_miss_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_mem_mode && rd_addr[ADDR_W-1:CH_W] != cfg_base) |-> (fifo_pop == '0));
  p_null_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_mem_mode && rd_addr == '1) |-> (fifo_pop == '0));
  p_lat_one_r6: assert property (@(posedge clk) disable iff (rst)
    (|fifo_pop && !cfg_lat2) |=> out_val);
  p_lat_two_r6: assert property (@(posedge clk) disable iff (rst)
    (|fifo_pop && cfg_lat2) |-> ##2 out_val);
  p_cell_eof_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pkt_mode && $past(!cfg_pkt_mode) && $past(!cfg_pkt_mode, 2))
      |-> (!out_eof_oe && !out_eof));
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop & fifo_empty) == '0);
  p_val_driven_r9: assert property (@(posedge clk) disable iff (rst)
    out_val |-> out_oe);
  p_poll_driven_r11: assert property (@(posedge clk) disable iff (rst)
    poll_avail |-> poll_oe);
  p_idle_data_r9: assert property (@(posedge clk) disable iff (rst)
    !out_val |-> (out_data == '0));
endmodule

bind rx_read_port rx_read_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_mem_mode (cfg_mem_mode),
  .cfg_lat2     (cfg_lat2),
  .cfg_pkt_mode (cfg_pkt_mode),
  .cfg_base     (cfg_base),
  .rd_en_n      (rd_en_n),
  .rd_addr      (rd_addr),
  .fifo_empty   (fifo_empty),
  .fifo_pop     (fifo_pop),
  .out_data     (out_data),
  .out_eof      (out_eof),
  .out_val      (out_val),
  .out_oe       (out_oe),
  .out_eof_oe   (out_eof_oe),
  .poll_avail   (poll_avail),
  .poll_oe      (poll_oe)
);

// File: tb/sim_rx_read_port.sv
`timescale 1ns/1ps
module sim_rx_read_port;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mem_mode = 1'b0, cfg_lat2 = 1'b0, cfg_pkt_mode = 1'b1;
  logic [2:0] cfg_base = 3'd3;
  logic rd_en_n = 1'b1;
  logic [4:0] rd_addr = 5'h1F;
  logic [3:0] fifo_empty = 4'hF;
  logic [4*DW-1:0] fifo_data = '0;
  logic [3:0] fifo_sof = '0, fifo_eof = '0, fifo_err = '0;
  logic [3:0] fifo_pop;
  logic [DW-1:0] out_data;
  logic out_par, out_sof, out_eof, out_err, out_val, out_oe, out_eof_oe;
  logic poll_avail, poll_oe;

  always #2.5 clk = ~clk;

  rx_read_port #(.DATA_W(DW)) u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // queue word: {err, eof, sof, data}
  logic [34:0] fq [4][$];
  int fpos [4];
  int flen [4];
  // model state
  logic m_sel_hit = 1'b0;
  logic [1:0] m_sel_ch = '0;
  logic [38:0] m_s1, m_s2;
  logic m_poe = 1'b0, m_pav = 1'b0;
  localparam logic [38:0] IDLE_BEAT = {6'b0, 1'b1, 32'b0};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input int c);
    logic [34:0] w;
    if (fpos[c] == 0) flen[c] = 1 + int'($urandom % 4);
    w[31:0] = $urandom;
    w[32] = (fpos[c] == 0);
    w[33] = (fpos[c] == flen[c] - 1);
    w[34] = w[33] && ($urandom % 6 == 0);
    fq[c].push_back(w);
    fpos[c] = (fpos[c] == flen[c] - 1) ? 0 : fpos[c] + 1;
  endtask

  task automatic refresh();
    for (int i = 0; i < 4; i++) begin
      fifo_empty[i] = (fq[i].size() == 0);
      fifo_data[i*DW +: DW] = fq[i].size() > 0 ? fq[i][0][31:0] : '0;
      fifo_sof[i] = fq[i].size() > 0 ? fq[i][0][32] : 1'b0;
      fifo_eof[i] = fq[i].size() > 0 ? fq[i][0][33] : 1'b0;
      fifo_err[i] = fq[i].size() > 0 ? fq[i][0][34] : 1'b0;
    end
  endtask

  task automatic step(input logic en, input logic [4:0] a, input int push_pct);
    logic hit, drv, rd, vld;
    logic [1:0] ch, rch;
    logic [34:0] w;
    logic [3:0] epop;
    logic [38:0] beat, exp;
    logic np_oe, np_av;
    @(negedge clk);
    if (int'($urandom % 100) < push_pct) push(int'($urandom % 4));
    refresh();
    rd_en_n = en;
    rd_addr = a;
    #0.5;
    hit = (a[4:2] == cfg_base) && (a != 5'h1F);
    ch = a[1:0];
    if (cfg_mem_mode) begin
      drv = !en && hit; rch = ch; rd = drv;
    end else begin
      drv = m_sel_hit; rch = m_sel_ch; rd = !en && m_sel_hit;
    end
    vld = rd && (fq[rch].size() > 0);
    w = vld ? fq[rch][0] : '0;
    epop = vld ? (4'b1 << rch) : 4'b0;
    check("R2 R3 R4 R5 R9 pop strobe", 64'(fifo_pop), 64'(epop));
    np_oe = hit;
    np_av = hit && (fq[ch].size() > 0);
    beat = {drv, drv && cfg_pkt_mode, vld, w[32], vld && cfg_pkt_mode && w[33],
            w[34], ~^w[31:0], w[31:0]};
    @(posedge clk);
    #1;
    if (vld) void'(fq[rch].pop_front());
    if (!cfg_mem_mode && en) begin m_sel_hit = hit; m_sel_ch = ch; end
    m_s2 = m_s1; m_s1 = beat;
    m_poe = np_oe; m_pav = np_av;
    refresh();
    exp = cfg_lat2 ? m_s2 : m_s1;
    check("R1 R6 R7 R8 R10 output beat",
          64'({out_oe, out_eof_oe, out_val, out_sof, out_eof, out_err, out_par, out_data}),
          64'(exp));
    check("R11 poll result", 64'({poll_oe, poll_avail}), 64'({m_poe, m_pav}));
  endtask

  // configuration changes only while the port is idle
  task automatic set_cfg(input logic mm, input logic l2, input logic pk, input logic [2:0] b);
    for (int i = 0; i < 3; i++) step(1'b1, 5'h1F, 0);
    cfg_mem_mode = mm; cfg_lat2 = l2; cfg_pkt_mode = pk; cfg_base = b;
    step(1'b1, 5'h1F, 0);
  endtask

  task automatic rand_run(input int n);
    logic [4:0] a;
    int r;
    for (int i = 0; i < n; i++) begin
      r = int'($urandom % 10);
      if (r < 6) a = {cfg_base, 2'(($urandom % 4))};
      else if (r < 8) a = 5'($urandom);
      else a = 5'h1F;
      step(($urandom % 10) < 4, a, 55);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_s1 = IDLE_BEAT; m_s2 = IDLE_BEAT;
    for (int i = 0; i < 4; i++) begin fpos[i] = 0; flen[i] = 1; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 reset outputs",
          64'({out_oe, out_eof_oe, out_val, out_sof, out_eof, out_err, out_par, out_data,
               poll_oe, poll_avail, fifo_pop}),
          64'({IDLE_BEAT, 2'b00, 4'b0000}));

    // R2 latched scheme: fill, select channel 2, read it dry and beyond
    for (int i = 0; i < 3; i++) push(2);
    push(1);
    step(1'b1, {3'd3, 2'd2}, 0);
    for (int i = 0; i < 4; i++) step(1'b0, {3'd3, 2'd1}, 0);  // poll ch1 while reading ch2
    step(1'b1, {3'd5, 2'd1}, 0);                              // other device: deselect (R9)
    step(1'b0, {3'd3, 2'd1}, 0);

    // R5 null address with base all ones, direct scheme, two-cycle latency
    set_cfg(1'b1, 1'b1, 1'b1, 3'd7);
    push(3); push(3);
    step(1'b0, 5'h1F, 0);
    step(1'b0, 5'h1E, 0);
    step(1'b0, 5'h1F, 0);
    step(1'b0, 5'h1F, 0);
    // R11 vs read in the same cycle: read last word of ch3 while polling it
    step(1'b0, 5'h1F, 0);
    step(1'b0, {3'd7, 2'd3}, 0);
    step(1'b0, {3'd7, 2'd3}, 0);
    step(1'b1, {3'd7, 2'd3}, 0);
    step(1'b1, 5'h1F, 0);

    // R8 cell mode
    set_cfg(1'b0, 1'b0, 1'b0, 3'd1);
    rand_run(300);
    set_cfg(1'b0, 1'b1, 1'b1, 3'd6);
    rand_run(300);
    set_cfg(1'b1, 1'b0, 1'b1, 3'd0);
    rand_run(300);
    set_cfg(1'b1, 1'b1, 1'b0, 3'd7);
    rand_run(300);
    set_cfg(1'b0, 1'b0, 1'b1, 3'd7);
    rand_run(300);
    for (int i = 0; i < 3; i++) step(1'b1, 5'h1F, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule